// File: doc/BRIEF.md
# Packed Single-Precision Compare Unit

This block takes two 64-bit operands, each carrying two independent single-precision values, and compares them lane by lane. For every lane it returns a 32-bit mask that is all ones when the selected relation holds and all zeros when it does not. Three relations are offered: equal, greater-than and greater-or-equal. The lane results go back to the same bit positions they came from.

The ordering is not IEEE-754 ordering. Denormal inputs are first forced to a zero of the same sign. Both zeros are equal. After that, every pattern is treated as an ordinary signed-magnitude number, including infinities and NaNs, so the unit never reports an unordered outcome. There are no exception flags, no rounding and no NaN signalling. The result and its valid flag are registered one clock after an accepted input.

Top module: `packed_fcmp_unit`

## Requirements
- R1: Each operand has two lanes, bits 31:0 (lane 0) and bits 63:32 (lane 1). Each lane's mask is written to the same bits of `result`, and it depends only on that lane's inputs.
- R2: Before the comparison, a lane value whose 8-bit exponent field (bits 30:23) is zero is replaced by a zero with the same sign bit (bit 31). This makes any denormal compare like a zero of its own sign.
- R3: Two lane values are equal when their flushed patterns are identical, or when both are zero of either sign (the OR of the two values, excluding bit 31, is zero).
- R4: When two unequal values have different sign bits, the one with bit 31 set is the lesser.
- R5: When two unequal values share a sign, the unsigned comparison of the 32-bit patterns gives the order, and that order is inverted when both are negative.
- R6: Infinity (exponent all ones, mantissa zero) and NaN (exponent all ones, mantissa nonzero) are ordered purely by their patterns, as in R4 and R5. No unordered result exists.
- R7: `op_sel` encodes 2'b00 as equal, 2'b01 as greater-than (src_a > src_b) and 2'b10 as greater-or-equal. A lane mask is 32'hFFFF_FFFF when the relation holds and 32'h0000_0000 otherwise. The value 2'b11 always gives an all-zero result.
- R8: When `in_valid` is high at a rising edge, `result` takes the masks at that edge and `out_valid` is high for the following cycle. When `in_valid` is low at an edge, `out_valid` is low after that edge.
- R9: While `rst_n` is low at a rising edge, both `out_valid` and `result` are cleared to zero.
- R10: While `in_valid` is low, `result` holds its last value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and op are valid this cycle |
| op_sel | input | 2 | Relation select (00 eq, 01 gt, 10 ge, 11 reserved) |
| src_a | input | 64 | First operand, two packed singles |
| src_b | input | 64 | Second operand, two packed singles |
| out_valid | output | 1 | Result register holds a fresh result |
| result | output | 64 | Two 32-bit lane masks |

## Verification
Each result is due exactly one rising edge after the cycle in which `in_valid` is high. The bench drives inputs on the falling edge, drops `in_valid` on the next falling edge, and samples `result` and `out_valid` right there, half a period after the capturing edge. The hold and reset checks read the outputs one falling edge after their stimulus, once the edge that could have changed the register has passed. Expected masks come from a signed-key model of the lane ordering in the bench, which shares no structure with the RTL.

// File: rtl/fcmp_pkg.sv
// Shared types for the packed single-precision compare unit.
package fcmp_pkg;

    // Relation select carried on op_sel.
    typedef enum logic [1:0] {
        OP_EQ  = 2'b00,
        OP_GT  = 2'b01,
        OP_GE  = 2'b10,
        OP_RSV = 2'b11
    } cmp_op_e;

    // Outcome of ordering one lane value against another.
    typedef enum logic [1:0] {
        REL_LESS    = 2'b00,
        REL_EQUAL   = 2'b01,
        REL_GREATER = 2'b10
    } rel_e;

endpackage

// File: rtl/fcmp_lane_flush.sv
// Forces a single-precision value whose exponent field is zero to a
// signed zero. Assumes sign in the top bit and exponent just below it.
module fcmp_lane_flush #(
    parameter int LANE_W = 32,
    parameter int EXP_W  = 8
) (
    input  logic [LANE_W-1:0] raw_val,
    output logic [LANE_W-1:0] flat_val
);
    localparam int MAN_W = LANE_W - 1 - EXP_W;

    logic exp_is_zero;

    // Detect an all-zero exponent and keep only the sign when it is zero.
    always_comb begin
        exp_is_zero = (raw_val[LANE_W-2 -: EXP_W] == '0);
        if (exp_is_zero)
            flat_val = {raw_val[LANE_W-1], {(LANE_W-1){1'b0}}};
        else
            flat_val = raw_val;
    end

    // MAN_W documents the field split; it must leave room for a mantissa.
    initial begin
        if (MAN_W < 1) $error("fcmp_lane_flush: exponent too wide for lane");
    end
endmodule

// File: rtl/fcmp_lane_order.sv
// Orders two flushed lane values as signed-magnitude numbers. Every
// pattern is ordinary (no unordered outcome). Assumes flushed inputs.
module fcmp_lane_order
    import fcmp_pkg::*;
#(
    parameter int LANE_W = 32
) (
    input  logic [LANE_W-1:0] lhs,
    input  logic [LANE_W-1:0] rhs,
    output rel_e              rel
);
    logic both_zero;
    logic same_bits;
    logic sign_split;
    logic lhs_below;

    // Equality first, then sign split, then raw unsigned order.
    always_comb begin
        both_zero  = ~|(lhs[LANE_W-2:0] | rhs[LANE_W-2:0]);
        same_bits  = (lhs == rhs);
        sign_split = lhs[LANE_W-1] ^ rhs[LANE_W-1];
        lhs_below  = (lhs < rhs);
        if (same_bits || both_zero)
            rel = REL_EQUAL;
        else if (sign_split)
            rel = lhs[LANE_W-1] ? REL_LESS : REL_GREATER;
        else if (lhs[LANE_W-1] ^ lhs_below)
            rel = REL_LESS;
        else
            rel = REL_GREATER;
    end
endmodule

// File: rtl/fcmp_lane_mask.sv
// Turns a lane relation and the selected op into an all-ones or
// all-zeros mask. The reserved op always yields zero.
module fcmp_lane_mask
    import fcmp_pkg::*;
#(
    parameter int LANE_W = 32
) (
    input  rel_e              rel,
    input  cmp_op_e           op,
    output logic [LANE_W-1:0] mask
);
    logic hit;

    // Decide whether the relation satisfies the op, then widen the bit.
    always_comb begin
        unique case (op)
            OP_EQ:   hit = (rel == REL_EQUAL);
            OP_GT:   hit = (rel == REL_GREATER);
            OP_GE:   hit = (rel == REL_GREATER) || (rel == REL_EQUAL);
            default: hit = 1'b0;
        endcase
        mask = {LANE_W{hit}};
    end
endmodule

// File: rtl/packed_fcmp_unit.sv
// Packed single-precision compare: LANES independent lanes, each
// flushed, ordered and masked, with one register stage at the output.
// Assumes synchronous active-low reset and rising-edge clocking.
module packed_fcmp_unit
    import fcmp_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int LANE_W = 32,
    parameter int EXP_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [1:0]                op_sel,
    input  logic [LANES*LANE_W-1:0]   src_a,
    input  logic [LANES*LANE_W-1:0]   src_b,
    output logic                      out_valid,
    output logic [LANES*LANE_W-1:0]   result
);
    localparam int DATA_W = LANES * LANE_W;

    cmp_op_e           op_q;
    logic [DATA_W-1:0] mask_d;

    // Decode the op field once for all lanes.
    always_comb begin
        op_q = cmp_op_e'(op_sel);
    end

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        logic [LANE_W-1:0] a_flat;
        logic [LANE_W-1:0] b_flat;
        rel_e              rel;

        fcmp_lane_flush #(.LANE_W(LANE_W), .EXP_W(EXP_W)) u_flush_a (
            .raw_val  (src_a[ln*LANE_W +: LANE_W]),
            .flat_val (a_flat)
        );
        fcmp_lane_flush #(.LANE_W(LANE_W), .EXP_W(EXP_W)) u_flush_b (
            .raw_val  (src_b[ln*LANE_W +: LANE_W]),
            .flat_val (b_flat)
        );
        fcmp_lane_order #(.LANE_W(LANE_W)) u_order (
            .lhs (a_flat),
            .rhs (b_flat),
            .rel (rel)
        );
        fcmp_lane_mask #(.LANE_W(LANE_W)) u_mask (
            .rel  (rel),
            .op   (op_q),
            .mask (mask_d[ln*LANE_W +: LANE_W])
        );
    end

    // Register the valid flag every cycle; clear it in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Capture the masks only on accepted inputs; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)        result <= '0;
        else if (in_valid) result <= mask_d;
    end
endmodule

// File: rtl/packed_fcmp_unit_sva.sv
// Checker for packed_fcmp_unit, attached by bind. Observes ports only.
module packed_fcmp_unit_sva #(
    parameter int LANES  = 2,
    parameter int LANE_W = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic [1:0]              op_sel,
    input logic [LANES*LANE_W-1:0] src_a,
    input logic [LANES*LANE_W-1:0] src_b,
    input logic                    out_valid,
    input logic [LANES*LANE_W-1:0] result
);
    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_reset_clears_R9: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0));
    assert_result_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !in_valid && $past(rst_n)) |=> $stable(result));
    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'b11) |=> (result == '0));
    assert_identical_equal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'b00 && src_a == src_b) |=> (result == '1));
    assert_identical_not_gt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'b01 && src_a == src_b) |=> (result == '0));

    for (genvar ln = 0; ln < LANES; ln++) begin : g_form
        assert_lane_mask_form_R7: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (result[ln*LANE_W +: LANE_W] == '0 ||
                           result[ln*LANE_W +: LANE_W] == '1));
    end
endmodule

bind packed_fcmp_unit packed_fcmp_unit_sva #(.LANES(LANES), .LANE_W(LANE_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .src_a     (src_a),
    .src_b     (src_b),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/packed_fcmp_unit_bench.sv
// Directed bench for packed_fcmp_unit: one task per scenario.
module packed_fcmp_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op_sel = 2'b00;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        out_valid;
    logic [63:0] result;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    localparam logic [31:0] PZ = 32'h0000_0000, NZ = 32'h8000_0000;
    localparam logic [31:0] PDN = 32'h0000_0001, NDN = 32'h8040_0000;
    localparam logic [31:0] PINF = 32'h7F80_0000, NINF = 32'hFF80_0000;
    localparam logic [31:0] PNAN = 32'h7FC0_0000, NNAN = 32'hFFC0_0000;
    localparam logic [31:0] P1 = 32'h3F80_0000, N1 = 32'hBF80_0000;
    localparam logic [31:0] P2 = 32'h4000_0000, N2 = 32'hC000_0000;

    always #2 clk = ~clk;

    packed_fcmp_unit u_packed_fcmp_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result)
    );

    // Model: flush, then map to a signed key (sign ? -magnitude : magnitude).
    function automatic longint key_of(input logic [31:0] x);
        longint mag;
        mag = (x[30:23] == 8'h00) ? 0 : longint'(x[30:0]);
        return x[31] ? -mag : mag;
    endfunction

    function automatic logic [31:0] model_lane(input logic [31:0] a, b, input logic [1:0] op);
        longint ka = key_of(a);
        longint kb = key_of(b);
        case (op)
            2'b00:   return (ka == kb) ? '1 : '0;
            2'b01:   return (ka >  kb) ? '1 : '0;
            2'b10:   return (ka >= kb) ? '1 : '0;
            default: return '0;
        endcase
    endfunction

    task automatic report(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Apply one vector, sample at the next falling edge, compare with model.
    task automatic run_vec(input string tag, input logic [63:0] a, b, input logic [1:0] op);
        logic [63:0] exp;
        exp = {model_lane(a[63:32], b[63:32], op), model_lane(a[31:0], b[31:0], op)};
        @(negedge clk);
        src_a = a; src_b = b; op_sel = op; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        report({tag, " result"}, result, exp);
        report({tag, " valid R8"}, {63'd0, out_valid}, 64'd1);
    endtask

    task automatic all_ops(input string tag, input logic [31:0] a0, b0, a1, b1);
        for (int op = 0; op < 3; op++)
            run_vec(tag, {a1, a0}, {b1, b0}, 2'(op));
    endtask

    task automatic test_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        report("R9 reset valid", {63'd0, out_valid}, 64'd0);
        report("R9 reset result", result, 64'd0);
        rst_n = 1'b1;
    endtask

    task automatic test_zeros;
        all_ops("R3 signed zeros", PZ, NZ, NZ, NZ);
        all_ops("R3 zero vs one", PZ, P1, NZ, N1);
    endtask

    task automatic test_denormals;
        all_ops("R2 denormals", PDN, PZ, NDN, PZ);
        all_ops("R2 denormal vs denormal", PDN, NDN, NDN, 32'h8000_0005);
        all_ops("R2 denormal sign", NDN, P1, PDN, N1);
    endtask

    task automatic test_signs;
        all_ops("R4 mixed signs", N1, P1, P2, N2);
        all_ops("R4 same magnitude", NINF, PINF, P1, N1);
    endtask

    task automatic test_same_sign;
        all_ops("R5 positive order", P2, P1, P1, P2);
        all_ops("R5 negative order", N2, N1, N1, N2);
    endtask

    task automatic test_infnan;
        all_ops("R6 inf vs nan", PINF, PNAN, NINF, NNAN);
        all_ops("R6 nan vs value", PNAN, P2, NNAN, N2);
        all_ops("R6 nan equal", PNAN, PNAN, NNAN, PNAN);
    endtask

    task automatic test_reserved;
        run_vec("R7 reserved op", {P2, PZ}, {P1, NZ}, 2'b11);
        run_vec("R7 reserved equal", {P1, P1}, {P1, P1}, 2'b11);
    endtask

    task automatic test_lanes;
        run_vec("R1 lane split eq", {P1, P2}, {P1, P1}, 2'b00);
        run_vec("R1 lane split gt", {P1, P2}, {P1, P1}, 2'b01);
        run_vec("R1 lane split lt", {N2, P1}, {N1, P1}, 2'b10);
    endtask

    // With in_valid low, change every other input and see result unchanged.
    task automatic test_hold;
        logic [63:0] held;
        run_vec("R10 load", {P2, P2}, {P1, P1}, 2'b01);
        held = result;
        @(negedge clk);
        src_a = '0; src_b = {P2, P2}; op_sel = 2'b00;
        @(negedge clk);
        report("R10 hold result", result, held);
        report("R10 hold valid R8", {63'd0, out_valid}, 64'd0);
        rst_n = 1'b0;
        @(negedge clk);
        report("R9 reset after use", result, 64'd0);
        rst_n = 1'b1;
    endtask

    task automatic test_random;
        for (int i = 0; i < 300; i++) begin
            logic [63:0] a, b;
            a = {$urandom, $urandom};
            b = (i % 5 == 0) ? a ^ 64'h8000_0000_0000_0000 : {$urandom, $urandom};
            run_vec("R5 R6 random", a, b, 2'($urandom_range(0, 3)));
        end
    endtask

    initial begin
        test_reset;
        test_zeros;
        test_denormals;
        test_signs;
        test_same_sign;
        test_infnan;
        test_reserved;
        test_lanes;
        test_hold;
        test_random;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule